// File: doc/BRIEF.md
# Line-Address Outstanding Request Tracker

This block sits between a processor's memory port and its cache controller and keeps track of every request that has been issued but not yet answered. Requests are split into two classes, read-class and write-class. Each class has its own small fully associative table, and each table entry is tagged with the cache-line address of its request (the request address with the low six offset bits dropped, so lines are 64 bytes). A new request gets a status in the cycle it is presented. It is accepted, refused because the tracker has no room, or refused because another request to the same line is already in flight in either table.

Completion responses name a line and the table it belongs to. A completion retires the matching entry and reports how many cycles that entry spent in flight. A completion for a line that is not in flight raises an error and changes nothing. A completion and a new request may arrive together; the completion is applied first, so the request sees the freed entry. The block also keeps four counters of alias refusals, sorted by the class of the new request and the class of the entry it collided with. An age watchdog raises a sticky alarm when an entry has been outstanding for the configured threshold.

Top module: `line_req_tracker`

## Requirements
- R1: After reset, both tables are empty, `outCount` is 0, the four alias counters are 0, `deadlockAlarm` is 0, and `reqStatus` reads 0 (none) while `reqValid` is low.
- R2: The `reqKind` codes 2 through 9 (store, RMW read, RMW write, load-linked, store-conditional, locked RMW read, locked RMW write, flush) are write-class. Every other code (0 load, 1 instruction fetch, 10 to 15) is read-class. An accepted request is placed in the table of its class.
- R3: A request is refused as full (`reqStatus` = 2) in two cases: the outstanding count, after any same-cycle retirement, is at or above `MAX_OUT`, or the table of its class has no free entry. This check comes before the alias check, so a refused-full request never bumps an alias counter. `outCount` never exceeds `MAX_OUT`.
- R4: A write-class request whose line is held in the read table is refused as aliased (`reqStatus` = 3) and increments `storeOnLoad`. Otherwise, if its line is held in the write table, it is refused as aliased and increments `storeOnStore`.
- R5: A read-class request whose line is held in the write table is refused as aliased and increments `loadOnStore`. Otherwise, if its line is held in the read table, it is refused as aliased and increments `loadOnLoad`.
- R6: Requests and completions are matched on address bits above bit 5 only; the low six bits have no effect on matching.
- R7: `outCount` always equals the number of occupied entries across both tables. It rises by one on an accept (`reqStatus` = 1) and falls by one on a successful completion.
- R8: A completion for a line held in the selected table (`cplIsWrite` = 1 selects the write table) retires that entry. In the same cycle, `cplLatency` equals the number of cycles since the cycle in which the request was accepted.
- R9: A completion whose line is not held in the selected table sets `cplError` in that cycle and leaves both tables and `outCount` unchanged.
- R10: When a completion and a request arrive in the same cycle, the retirement is applied first. Both the full check and the alias check see the tables without the retired entry.
- R11: The watchdog arms on an accept when it is idle and then runs for `DEAD_THRESH` cycles. When it expires, it sets `deadlockAlarm` if any entry's age is at least `DEAD_THRESH`. It re-arms if entries remain and goes idle otherwise. The alarm stays set until reset. An entry accepted in cycle N and never completed raises the alarm first in cycle N+`DEAD_THRESH`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A new request is presented this cycle |
| reqKind | input | 4 | Request kind code (see R2) |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqStatus | output | 2 | 0 none, 1 accepted, 2 full, 3 aliased |
| cplValid | input | 1 | A completion is presented this cycle |
| cplIsWrite | input | 1 | Completion targets the write table (1) or the read table (0) |
| cplAddr | input | ADDR_W | Byte address of the completing line |
| cplError | output | 1 | Completion matched no entry in the selected table |
| cplLatency | output | TIME_W | In-flight cycles of the retiring entry |
| outCount | output | clog2(2*ENTRIES+1) | Current number of outstanding requests |
| storeOnLoad | output | CNT_W | Write-class refusals caused by a read entry |
| storeOnStore | output | CNT_W | Write-class refusals caused by a write entry |
| loadOnLoad | output | CNT_W | Read-class refusals caused by a read entry |
| loadOnStore | output | CNT_W | Read-class refusals caused by a write entry |
| deadlockAlarm | output | 1 | Sticky watchdog alarm |

## Verification
The embedded properties check several invariants on every cycle. The outstanding counter must agree with the table occupancies, and it must stay within `MAX_OUT`. No line may appear twice in a table. An insert may only happen when a free entry exists, an alias refusal must not grow the count, an erroneous completion must leave the count alone, and the alarm must stay set once raised. Other behaviour can only be shown by the bench's scenarios: the split between the classes, which of the four counters moves, the completion-first ordering, the exact latency value, and the exact cycle in which the watchdog fires.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_ACCEPT = 2'd1,
    ST_FULL   = 2'd2,
    ST_ALIAS  = 2'd3
  } reqStatus_e;

  // Strobes from control to the table datapath
  typedef struct packed {
    logic insRd;
    logic insWr;
    logic retRd;
    logic retWr;
  } tblStrobe_t;

  // Kind codes 2..9 are write-class; everything else is read-class
  function automatic logic isWriteClass(input logic [3:0] kind);
    return (kind >= 4'd2) && (kind <= 4'd9);
  endfunction

endpackage

// File: rtl/lrt_cam.sv
module lrt_cam #(
  parameter int TAG_W   = 26,
  parameter int ENTRIES = 8,
  parameter int TIME_W  = 16,
  parameter int THRESH  = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [TAG_W-1:0]               lookTag,
  input  logic                           insert,
  input  logic [TAG_W-1:0]               retTag,
  input  logic                           retire,
  input  logic [TIME_W-1:0]              nowCycle,
  output logic                           lookHit,
  output logic                           retHit,
  output logic [TIME_W-1:0]              retIssue,
  output logic                           hasFree,
  output logic [$clog2(ENTRIES+1)-1:0]   occ,
  output logic                           anyAged
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OCC_W = $clog2(ENTRIES+1);

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tagMem   [ENTRIES];
  logic [TIME_W-1:0]  issueMem [ENTRIES];
  logic [ENTRIES-1:0] lookMatch, retMatch, retClear, agedVec;
  logic [IDX_W-1:0]   freeIdx;

  always_comb begin
    retIssue = '0;
    occ      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lookMatch[i] = valid[i] && (tagMem[i] == lookTag);
      retMatch[i]  = valid[i] && (tagMem[i] == retTag);
      agedVec[i]   = valid[i] && ((nowCycle - issueMem[i]) >= TIME_W'(THRESH));
      if (retMatch[i]) retIssue = issueMem[i];
      occ = occ + OCC_W'(valid[i]);
    end
    retClear = retire ? retMatch : '0;
    hasFree  = 1'b0;
    freeIdx  = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!valid[i] || retClear[i]) begin
        hasFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign lookHit = |(lookMatch & ~retClear);
  assign retHit  = |retMatch;
  assign anyAged = |agedVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valid <= '0;
    else       valid <= (valid & ~retClear) | (insert ? (ENTRIES'(1) << freeIdx) : '0);
  end

  always_ff @(posedge clk) begin
    if (insert) begin
      tagMem[freeIdx]   <= lookTag;
      issueMem[freeIdx] <= nowCycle;
    end
  end

  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)); // R4
  AST_INSERT_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    insert |-> hasFree); // R3

endmodule

// File: rtl/lrt_datapath.sv
module lrt_datapath
  import lrt_pkg::*;
#(
  parameter int TAG_W   = 26,
  parameter int ENTRIES = 8,
  parameter int TIME_W  = 16,
  parameter int THRESH  = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [TAG_W-1:0]             reqLine,
  input  logic [TAG_W-1:0]             cplLine,
  input  logic                         cplIsWrite,
  input  tblStrobe_t                   strb,
  output logic [1:0]                   lookHit,
  output logic [1:0]                   retHit,
  output logic [1:0]                   hasFree,
  output logic [$clog2(ENTRIES+1)-1:0] occRd,
  output logic [$clog2(ENTRIES+1)-1:0] occWr,
  output logic                         anyAged,
  output logic [TIME_W-1:0]            cplLatency
);
  localparam int OCC_W = $clog2(ENTRIES+1);

  logic [TIME_W-1:0] nowCycle;
  logic [1:0]        insVec, retVec, agedVec;
  logic [OCC_W-1:0]  occArr   [2];
  logic [TIME_W-1:0] issueArr [2];

  assign insVec = {strb.insWr, strb.insRd};
  assign retVec = {strb.retWr, strb.retRd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nowCycle <= '0;
    else       nowCycle <= nowCycle + 1'b1;
  end

  // index 0 = read-class table, index 1 = write-class table
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    lrt_cam #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .TIME_W(TIME_W), .THRESH(THRESH)) u_cam (
      .clk(clk), .rstN(rstN),
      .lookTag(reqLine), .insert(insVec[t]),
      .retTag(cplLine), .retire(retVec[t]),
      .nowCycle(nowCycle),
      .lookHit(lookHit[t]), .retHit(retHit[t]), .retIssue(issueArr[t]),
      .hasFree(hasFree[t]), .occ(occArr[t]), .anyAged(agedVec[t])
    );
  end

  assign occRd      = occArr[0];
  assign occWr      = occArr[1];
  assign anyAged    = |agedVec;
  assign cplLatency = nowCycle - issueArr[cplIsWrite];

endmodule

// File: rtl/lrt_ctrl.sv
module lrt_ctrl
  import lrt_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int MAX_OUT     = 12,
  parameter int DEAD_THRESH = 64,
  parameter int CNT_W       = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic [3:0]                       reqKind,
  input  logic                             cplValid,
  input  logic                             cplIsWrite,
  input  logic [1:0]                       lookHit,
  input  logic [1:0]                       retHit,
  input  logic [1:0]                       hasFree,
  input  logic [$clog2(ENTRIES+1)-1:0]     occRd,
  input  logic [$clog2(ENTRIES+1)-1:0]     occWr,
  input  logic                             anyAged,
  output tblStrobe_t                       strb,
  output logic [1:0]                       reqStatus,
  output logic                             cplError,
  output logic [$clog2(2*ENTRIES+1)-1:0]   outCount,
  output logic [CNT_W-1:0]                 storeOnLoad,
  output logic [CNT_W-1:0]                 storeOnStore,
  output logic [CNT_W-1:0]                 loadOnLoad,
  output logic [CNT_W-1:0]                 loadOnStore,
  output logic                             deadlockAlarm
);
  localparam int OCC_W = $clog2(2*ENTRIES+1);
  localparam int WD_W  = $clog2(DEAD_THRESH+1);

  logic             wc, cplOk, accept, aliasCross, aliasSame;
  logic [OCC_W-1:0] countAfter, countNext;
  logic             wdArmed;
  logic [WD_W-1:0]  wdTimer;
  reqStatus_e       status;

  assign wc         = isWriteClass(reqKind);
  assign cplOk      = cplValid && retHit[cplIsWrite];
  assign cplError   = cplValid && !retHit[cplIsWrite];
  assign countAfter = outCount - OCC_W'(cplOk);
  assign aliasCross = lookHit[!wc];
  assign aliasSame  = lookHit[wc];

  always_comb begin
    status = ST_NONE;
    if (reqValid) begin
      if ((countAfter >= OCC_W'(MAX_OUT)) || !hasFree[wc]) status = ST_FULL;
      else if (aliasCross || aliasSame)                      status = ST_ALIAS;
      else                                                   status = ST_ACCEPT;
    end
  end

  assign reqStatus  = status;
  assign accept     = (status == ST_ACCEPT);
  assign strb.insRd = accept && !wc;
  assign strb.insWr = accept && wc;
  assign strb.retRd = cplOk && !cplIsWrite;
  assign strb.retWr = cplOk && cplIsWrite;
  assign countNext  = countAfter + OCC_W'(accept);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCount     <= '0;
      storeOnLoad  <= '0;
      storeOnStore <= '0;
      loadOnLoad   <= '0;
      loadOnStore  <= '0;
    end else begin
      outCount <= countNext;
      if (status == ST_ALIAS) begin
        if (wc && aliasCross)       storeOnLoad  <= storeOnLoad + 1'b1;
        else if (wc)                storeOnStore <= storeOnStore + 1'b1;
        else if (aliasCross)        loadOnStore  <= loadOnStore + 1'b1;
        else                        loadOnLoad   <= loadOnLoad + 1'b1;
      end
    end
  end

  // Age watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdArmed       <= 1'b0;
      wdTimer       <= '0;
      deadlockAlarm <= 1'b0;
    end else if (wdArmed) begin
      if (wdTimer == WD_W'(1)) begin
        if (anyAged) deadlockAlarm <= 1'b1;
        if (countNext != '0) wdTimer <= WD_W'(DEAD_THRESH);
        else                 wdArmed <= 1'b0;
      end else begin
        wdTimer <= wdTimer - 1'b1;
      end
    end else if (accept) begin
      wdArmed <= 1'b1;
      wdTimer <= WD_W'(DEAD_THRESH);
    end
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    outCount == (OCC_W'(occRd) + OCC_W'(occWr))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= OCC_W'(MAX_OUT)); // R3
  AST_ALIAS_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (reqStatus == ST_ALIAS) |=> (outCount <= $past(outCount))); // R5
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cplError && reqStatus != ST_ACCEPT) |=> (outCount == $past(outCount))); // R9
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    deadlockAlarm |=> deadlockAlarm); // R11

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int ENTRIES     = 8,
  parameter int MAX_OUT     = 12,
  parameter int TIME_W      = 16,
  parameter int DEAD_THRESH = 64,
  parameter int CNT_W       = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [3:0]                     reqKind,
  input  logic [ADDR_W-1:0]              reqAddr,
  output logic [1:0]                     reqStatus,
  input  logic                           cplValid,
  input  logic                           cplIsWrite,
  input  logic [ADDR_W-1:0]              cplAddr,
  output logic                           cplError,
  output logic [TIME_W-1:0]              cplLatency,
  output logic [$clog2(2*ENTRIES+1)-1:0] outCount,
  output logic [CNT_W-1:0]               storeOnLoad,
  output logic [CNT_W-1:0]               storeOnStore,
  output logic [CNT_W-1:0]               loadOnLoad,
  output logic [CNT_W-1:0]               loadOnStore,
  output logic                           deadlockAlarm
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int OCC_W = $clog2(ENTRIES+1);

  tblStrobe_t       strb;
  logic [1:0]       lookHit, retHit, hasFree;
  logic [OCC_W-1:0] occRd, occWr;
  logic             anyAged;

  lrt_datapath #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .TIME_W(TIME_W), .THRESH(DEAD_THRESH)) u_dp (
    .clk(clk), .rstN(rstN),
    .reqLine(reqAddr[ADDR_W-1:OFS_W]), .cplLine(cplAddr[ADDR_W-1:OFS_W]),
    .cplIsWrite(cplIsWrite), .strb(strb),
    .lookHit(lookHit), .retHit(retHit), .hasFree(hasFree),
    .occRd(occRd), .occWr(occWr), .anyAged(anyAged), .cplLatency(cplLatency)
  );

  lrt_ctrl #(.ENTRIES(ENTRIES), .MAX_OUT(MAX_OUT), .DEAD_THRESH(DEAD_THRESH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind),
    .cplValid(cplValid), .cplIsWrite(cplIsWrite),
    .lookHit(lookHit), .retHit(retHit), .hasFree(hasFree),
    .occRd(occRd), .occWr(occWr), .anyAged(anyAged),
    .strb(strb), .reqStatus(reqStatus), .cplError(cplError), .outCount(outCount),
    .storeOnLoad(storeOnLoad), .storeOnStore(storeOnStore),
    .loadOnLoad(loadOnLoad), .loadOnStore(loadOnStore),
    .deadlockAlarm(deadlockAlarm)
  );

endmodule

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
  localparam int THRESH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, cplValid = 1'b0, cplIsWrite = 1'b0;
  logic [3:0]  reqKind = '0;
  logic [31:0] reqAddr = '0, cplAddr = '0;
  logic [1:0]  reqStatus;
  logic        cplError, deadlockAlarm;
  logic [15:0] cplLatency;
  logic [4:0]  outCount;
  logic [7:0]  storeOnLoad, storeOnStore, loadOnLoad, loadOnStore;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  line_req_tracker #(.DEAD_THRESH(THRESH)) u_line_req_tracker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr), .reqStatus(reqStatus),
    .cplValid(cplValid), .cplIsWrite(cplIsWrite), .cplAddr(cplAddr),
    .cplError(cplError), .cplLatency(cplLatency), .outCount(outCount),
    .storeOnLoad(storeOnLoad), .storeOnStore(storeOnStore),
    .loadOnLoad(loadOnLoad), .loadOnStore(loadOnStore),
    .deadlockAlarm(deadlockAlarm)
  );

  typedef struct packed {
    logic        rv;
    logic [3:0]  kind;
    logic [31:0] addr;
    logic        cv;
    logic        cw;
    logic [31:0] caddr;
    logic [1:0]  expSt;
    logic        expErr;
  } vec_t;

  // status: 1 accept, 2 full, 3 alias
  localparam vec_t VEC [12] = '{
    '{1'b1, 4'd0, 32'h1000, 1'b0, 1'b0, 32'h0,    2'd1, 1'b0}, // R2 load accepted
    '{1'b1, 4'd0, 32'h1020, 1'b0, 1'b0, 32'h0,    2'd3, 1'b0}, // R5 R6 load on load
    '{1'b1, 4'd2, 32'h1010, 1'b0, 1'b0, 32'h0,    2'd3, 1'b0}, // R4 store on load
    '{1'b1, 4'd2, 32'h2000, 1'b0, 1'b0, 32'h0,    2'd1, 1'b0}, // R2 store accepted
    '{1'b1, 4'd1, 32'h2004, 1'b0, 1'b0, 32'h0,    2'd3, 1'b0}, // R5 fetch on store
    '{1'b1, 4'd6, 32'h2030, 1'b0, 1'b0, 32'h0,    2'd3, 1'b0}, // R4 cond store on store
    '{1'b1, 4'd9, 32'h3000, 1'b0, 1'b0, 32'h0,    2'd1, 1'b0}, // R2 flush write-class
    '{1'b1, 4'd5, 32'h3040, 1'b0, 1'b0, 32'h0,    2'd1, 1'b0}, // R6 next line distinct
    '{1'b0, 4'd0, 32'h0,    1'b1, 1'b1, 32'h1000, 2'd0, 1'b1}, // R9 wrong table
    '{1'b1, 4'd8, 32'h1008, 1'b1, 1'b0, 32'h1000, 2'd1, 1'b0}, // R10 retire then accept
    '{1'b1, 4'd10,32'h2000, 1'b0, 1'b0, 32'h0,    2'd3, 1'b0}, // R2 R5 code 10 read-class
    '{1'b1, 4'd0, 32'h2000, 1'b1, 1'b1, 32'h2000, 2'd1, 1'b0}  // R10 retire then accept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [3:0] k, input logic [31:0] a,
                       input logic cv, input logic cw, input logic [31:0] ca);
    reqValid = rv; reqKind = k; reqAddr = a;
    cplValid = cv; cplIsWrite = cw; cplAddr = ca;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; cplValid = 1'b0;
    #1;
  endtask

  task automatic doReset();
    reqValid = 1'b0; cplValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    #(2000000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 outCount", 32'(outCount), 0);
    chk("R1 status", 32'(reqStatus), 0);
    chk("R1 alarm", 32'(deadlockAlarm), 0);
    chk("R1 counters", 32'({storeOnLoad, storeOnStore, loadOnLoad, loadOnStore}), 0);

    // Vector walk
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i].rv, VEC[i].kind, VEC[i].addr, VEC[i].cv, VEC[i].cw, VEC[i].caddr);
      chk($sformatf("R2-R10 vec%0d status", i), 32'(reqStatus), 32'(VEC[i].expSt));
      chk($sformatf("R9 vec%0d cplError", i), 32'(cplError), 32'(VEC[i].expErr));
      tick();
    end
    chk("R7 outCount after vectors", 32'(outCount), 4);
    chk("R4 storeOnLoad", 32'(storeOnLoad), 1);
    chk("R4 storeOnStore", 32'(storeOnStore), 1);
    chk("R5 loadOnLoad", 32'(loadOnLoad), 1);
    chk("R5 loadOnStore", 32'(loadOnStore), 2);

    // R3 table full and max outstanding
    doReset();
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 4'd0, 32'(i * 64), 1'b0, 1'b0, 32'h0);
      chk("R3 fill read table", 32'(reqStatus), 1);
      tick();
    end
    drive(1'b1, 4'd0, 32'(8 * 64), 1'b0, 1'b0, 32'h0);
    chk("R3 read table full", 32'(reqStatus), 2);
    tick();
    drive(1'b1, 4'd0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R3 full before alias", 32'(reqStatus), 2);
    tick();
    chk("R3 no alias count when full", 32'(loadOnLoad), 0);
    for (int i = 16; i < 20; i++) begin
      drive(1'b1, 4'd2, 32'(i * 64), 1'b0, 1'b0, 32'h0);
      chk("R3 fill write table", 32'(reqStatus), 1);
      tick();
    end
    chk("R7 outCount at max", 32'(outCount), 12);
    drive(1'b1, 4'd2, 32'(20 * 64), 1'b0, 1'b0, 32'h0);
    chk("R3 max outstanding", 32'(reqStatus), 2);
    tick();
    drive(1'b1, 4'd2, 32'(20 * 64), 1'b1, 1'b1, 32'(16 * 64));
    chk("R10 retire frees room", 32'(reqStatus), 1);
    chk("R10 no cpl error", 32'(cplError), 0);
    tick();
    chk("R7 outCount after swap", 32'(outCount), 12);

    // R8 latency with offset bits set
    doReset();
    drive(1'b1, 4'd1, 32'h4000, 1'b0, 1'b0, 32'h0);
    chk("R8 accept", 32'(reqStatus), 1);
    tick();
    for (int i = 0; i < 4; i++) tick();
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 32'h403F);
    chk("R8 latency", 32'(cplLatency), 5);
    chk("R6 R8 no error", 32'(cplError), 0);
    tick();
    chk("R8 retired", 32'(outCount), 0);
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 32'h4000);
    chk("R9 second completion errors", 32'(cplError), 1);
    tick();
    chk("R9 count unchanged", 32'(outCount), 0);

    // R11 no alarm when entries complete in time
    drive(1'b1, 4'd0, 32'h5000, 1'b0, 1'b0, 32'h0);
    tick();
    tick();
    drive(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 32'h5000);
    tick();
    for (int i = 0; i < 2 * THRESH; i++) tick();
    chk("R11 no alarm when drained", 32'(deadlockAlarm), 0);

    // R11 alarm timing
    doReset();
    drive(1'b1, 4'd2, 32'h6000, 1'b0, 1'b0, 32'h0);
    tick();
    for (int i = 0; i < THRESH - 1; i++) tick();
    chk("R11 alarm not yet", 32'(deadlockAlarm), 0);
    tick();
    chk("R11 alarm raised", 32'(deadlockAlarm), 1);
    for (int i = 0; i < 5; i++) tick();
    chk("R11 alarm sticky", 32'(deadlockAlarm), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule